// File: doc/BRIEF.md
# Short-Pulse Capturing Synchronizer

This block brings a single-bit asynchronous event into a destination clock domain. The event may be far shorter than one destination clock period. In its default mode, a capture flop uses the rising edge of the event as its clock and loads a constant one, so it records even a glitch-short event. A chain of destination-clock flops then carries that flag across. When the flag reaches the last stage, the capture flop is cleared asynchronously from the synchronized side. This re-arms it for the next event.

The block drives a clean synchronized level and a registered single-cycle pulse on the rising edge of that level. A parameter selects a plain flop-chain mode for inputs that are always at least one destination clock period wide. In that mode the capture flop is not built. Every stage gives the previous one a full destination clock period to settle before its value is used.

Top module: `pulse_catch_sync`

## Requirements
- R1: In narrow mode, a rising edge on `evt_in` of any width, including one that starts and ends between two clock edges, produces a high `sync_level`.
- R2: With `STAGES` = 2 and an event between edge n and edge n+1, `sync_level` is first high after edge n+2, and `sync_pulse` is high only after edge n+3.
- R3: Once `sync_level` is high, the capture flop is cleared. A later event, arriving after `sync_level` has fallen, is reported again as a separate event.
- R4: In narrow mode, each reported event holds `sync_level` high for exactly `STAGES` clock cycles.
- R5: `sync_pulse` is high for exactly one cycle, in the cycle after each rise of `sync_level`, and at no other time.
- R6: `rst` is active high and synchronous. While it is high, `sync_level` and `sync_pulse` read 0 and the capture flop is held clear. An event that arrives while `rst` is high, or an event whose capture is cut off by `rst` before `sync_level` rises, produces no output.
- R7: A second event that arrives while the capture flop is still set merges with the first and produces only one `sync_pulse`.
- R8: In wide mode (`MODE` = SYNC_WIDE), `sync_level` equals `evt_in` delayed by `STAGES` clock edges. `sync_pulse` follows the same one-cycle-after-rise rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination clock |
| rst | input | 1 | Synchronous active-high reset; also clears the capture flop |
| evt_in | input | 1 | Asynchronous event input |
| sync_level | output | 1 | Event flag synchronized to `clk` |
| sync_pulse | output | 1 | One-cycle pulse on the rising edge of `sync_level` |

## Verification
Two functions can act in the same window: the capture of a new event and the clearing of the capture flop by the synchronized side. The same holds for reset and a pending capture. The bench fires a second event one cycle after the first, while the flag is still set and not yet cleared, and requires exactly one pulse at the first event's cycle. It also raises reset immediately after an event, before the flag reaches the chain's end, and requires that no pulse ever appears.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
    typedef enum logic {
        SYNC_NARROW = 1'b0,
        SYNC_WIDE   = 1'b1
    } sync_mode_e;

    localparam int MIN_STAGES = 2;

    // Clamp a requested stage count to the settling minimum.
    function automatic int legal_stages(input int req);
        return (req < MIN_STAGES) ? MIN_STAGES : req;
    endfunction
endpackage

// File: rtl/pcs_capture.sv
`timescale 1ns/1ps
module pcs_capture (
    input  logic evt_in,
    input  logic clr,
    output logic armed_q
);
    // Event edge is the clock; D is a constant one; clear wins.
    always_ff @(posedge evt_in or posedge clr) begin
        if (clr) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end
endmodule

// File: rtl/pcs_chain.sv
`timescale 1ns/1ps
module pcs_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int N = pcs_pkg::legal_stages(STAGES);

    logic [N-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= 1'b0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[N-1];
endmodule

// File: rtl/pcs_rise_pulse.sv
`timescale 1ns/1ps
module pcs_rise_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            level_d <= level;
            pulse   <= level & ~level_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse) else $error("pulse wider than one cycle"); // R5
    AST_RISE_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |=> pulse) else $error("rise without pulse"); // R5
endmodule

// File: rtl/pulse_catch_sync.sv
`timescale 1ns/1ps
module pulse_catch_sync #(
    parameter pcs_pkg::sync_mode_e MODE = pcs_pkg::SYNC_NARROW,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_in,
    output logic sync_level,
    output logic sync_pulse
);
    logic chain_d;

    if (MODE == pcs_pkg::SYNC_NARROW) begin : g_narrow
        logic armed;
        logic cap_clr;

        // Re-arm from the synchronized side, or on reset.
        assign cap_clr = rst | sync_level;

        pcs_capture u_cap (
            .evt_in  (evt_in),
            .clr     (cap_clr),
            .armed_q (armed)
        );
        assign chain_d = armed;

        AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            $rose(sync_level) |=> sync_level) else $error("level too short"); // R4
        AST_PULSE_WITH_LEVEL: assert property (@(posedge clk) disable iff (rst)
            sync_pulse |-> sync_level) else $error("pulse without level"); // R5
    end else begin : g_wide
        assign chain_d = evt_in;
    end

    pcs_chain #(.STAGES(STAGES)) u_chain (
        .clk (clk),
        .rst (rst),
        .d   (chain_d),
        .q   (sync_level)
    );

    pcs_rise_pulse u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sync_level),
        .pulse (sync_pulse)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!sync_level && !sync_pulse)) else $error("reset not clearing"); // R6
endmodule

// File: tb/pulse_catch_sync_bench.sv
`timescale 1ns/1ps
module pulse_catch_sync_bench;
    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt = 1'b0;
    logic wevt = 1'b0;
    logic level, pulse, wlevel, wpulse;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int run_len = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pulse_catch_sync #(.MODE(pcs_pkg::SYNC_NARROW), .STAGES(STG)) u_pulse_catch_sync (
        .clk(clk), .rst(rst), .evt_in(evt), .sync_level(level), .sync_pulse(pulse));

    pulse_catch_sync #(.MODE(pcs_pkg::SYNC_WIDE), .STAGES(STG)) u_pulse_catch_sync_wide (
        .clk(clk), .rst(rst), .evt_in(wevt), .sync_level(wlevel), .sync_pulse(wpulse));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: short event between edges, expected pulse cycle pushed.
    task automatic narrow_event(input bit expect_pulse);
        @(posedge clk);
        #1;
        if (expect_pulse) exp_q.push_back(cyc + 3); // R2: level at n+2, pulse at n+3
        evt = 1'b1;
        #0.4;
        evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Monitor: pops expected pulse cycles, measures level width.
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected pulse", 1, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(cyc == e, "R1/R2 pulse cycle", cyc, e);
                end
            end
            if (level) run_len++;
            else if (run_len != 0) begin
                check(run_len == STG, "R4 level width", run_len, STG);
                run_len = 0;
            end
        end else begin
            run_len = 0;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        check(level == 0 && pulse == 0, "R6 reset state", {level, pulse}, 0);
        // R6: event during reset is dropped
        @(posedge clk); #1; evt = 1'b1; #0.4; evt = 1'b0;
        idle(2);
        #1 rst = 1'b0;
        idle(8);

        // R1/R2/R4: single short events, re-armed each time (R3)
        narrow_event(1'b1);
        idle(8);
        narrow_event(1'b1);
        idle(8);
        narrow_event(1'b1);
        idle(8);

        // R7: second event while capture still set merges
        narrow_event(1'b1);
        narrow_event(1'b0);
        idle(8);

        // R3: rearm right after level falls (level falls at n+4)
        narrow_event(1'b1);
        idle(4);
        narrow_event(1'b1);
        idle(8);

        // R6: reset cuts off a pending capture
        narrow_event(1'b0);
        #1 rst = 1'b1;
        idle(2);
        #1 rst = 1'b0;
        idle(8);

        // R8: wide mode, input high for three cycles
        begin
            int n;
            @(posedge clk); #1;
            n = cyc;
            wevt = 1'b1;
            fork
                begin
                    idle(3); #1; wevt = 1'b0;
                end
                begin
                    for (int k = 0; k < 7; k++) begin
                        @(negedge clk);
                        check(wlevel == (cyc >= n + 2 && cyc <= n + 4), "R8 wide level",
                              wlevel, (cyc >= n + 2 && cyc <= n + 4));
                        check(wpulse == (cyc == n + 3), "R8 wide pulse",
                              wpulse, (cyc == n + 3));
                    end
                end
            join
        end
        idle(4);

        check(exp_q.size() == 0, "R1/R7 missing pulses", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule